// File: doc/BRIEF.md
# Vectored System Call Entry and Return Unit

This unit executes the two control-transfer instructions of the vectored system call scheme in a 64-bit core. It handles the call, which enters a kernel handler chosen by a 7-bit level field, and the privileged return that goes back to the caller. The unit owns the link and count registers. A call saves its return address and the caller's machine state in those two registers. The ordinary save/restore registers are not used. The return reloads the program counter and the machine state from the same two registers.

Each instruction is presented for one cycle on `exec_valid`, together with the current PC, the machine state register (MSR), the facility control register, the interrupt-location mode and a feature-present flag. One clock later the unit answers with a single one-cycle result. That result is one of:

- a fetch redirect with a new MSR,
- a facility-unavailable exception carrying an updated control register,
- a privileged-instruction exception,
- an illegal-instruction exception.

Any other instruction word, including the ordinary system call under the same primary opcode, gives no result.

The handler address is a fixed base plus 32 bytes per level. The base depends on the effective interrupt-location mode. That mode is suppressed when the entry moves into hypervisor state or when the caller runs with translation off.

Top module: `svc_vector_unit`

## Requirements
- R1: A call is recognised when instruction bits [31:26] equal 17 and bits [1:0] equal 0b01. The ordinary system call, with bits [1:0] = 0b10 under the same opcode, produces no output pulse and leaves the link and count registers unchanged.
- R2: The level is instruction bits [11:5]. The handler address is the selected base plus level × 0x20.
- R3: With effective mode 3 the base is 0xC000_0000_0000_3000. With any other effective mode the base is 0x0000_0000_0001_7000.
- R4: The effective mode is forced to zero when `to_hyp` is high, or when MSR bit 5 (instruction relocation) or MSR bit 4 (data relocation) is clear.
- R5: On an enabled call, the cycle after the strobe shows the link register equal to PC + 4, the count register equal to the old MSR, and `redirect_valid` high with `redirect_pc` equal to the handler address.
- R6: The new MSR after a call has these bits and no others:
  - bit 15 (external interrupt enable), copied from the old MSR;
  - bit 1 (recoverable interrupt), copied from the old MSR;
  - bits 5 and 4, both set only when the effective mode is nonzero.
  
  `msr_wr` pulses with the new MSR.
- R7: If `feat_present` is low or control register bit 12 is clear, a call raises `fu_exc` instead of entering the handler. `fscr_new` then equals the input register with bits [63:56] replaced by cause code 12. There is no redirect, and the link and count registers are unchanged.
- R8: The return is recognised when bits [31:26] equal 19 and bits [10:1] equal 82. When MSR bit 14 (problem state) is clear, it redirects to the link register value and writes the count register value as the new MSR.
- R9: A return executed with MSR bit 14 set raises only `priv_exc`. There is no redirect and no MSR write.
- R10: Nonzero reserved bits raise only `ill_exc`, and this takes precedence over the facility and privilege checks. The reserved bits are [25:12] and [4:2] for the call, and [25:15] and [0] for the return.
- R11: After reset the link and count registers are zero and all result pulses are low. Each pulse lasts exactly one cycle, and at most one of `redirect_valid`, `fu_exc`, `priv_exc` and `ill_exc` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | One-cycle execute strobe |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| msr | input | 64 | Current machine state |
| fscr | input | 64 | Facility control register |
| ail_mode | input | 2 | Interrupt-location mode |
| to_hyp | input | 1 | Entry would move into hypervisor state |
| feat_present | input | 1 | The core implements the vectored call |
| lr | output | 64 | Link register |
| ctr | output | 64 | Count register |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 64 | New PC for the redirect |
| msr_wr | output | 1 | One-cycle MSR write strobe |
| msr_new | output | 64 | New MSR value |
| fu_exc | output | 1 | Facility-unavailable exception |
| fscr_new | output | 64 | Control register with cause code inserted |
| priv_exc | output | 1 | Privileged-instruction exception |
| ill_exc | output | 1 | Illegal-instruction exception |

## Verification
The bench exercises each way the interrupt-location mode is cancelled: a hypervisor transition, and translation only partly on. A design that tested the raw mode instead of the effective one would set the relocation bits and jump to the high base. Level 127 under the high base checks the stride arithmetic at its top value. A truncated or mis-shifted level would land on the wrong 32-byte slot. Illegal encodings are combined with a disabled facility and with problem state. A design with the checks in the wrong order would report the facility or privilege fault instead. Finally, the ordinary system call and a disabled call are each followed by a check that the link register kept its earlier value. This catches a design that writes the register before deciding whether to enter.

// File: rtl/svc_pkg.sv
package svc_pkg;

    localparam int XLEN     = 64;
    localparam int ILEN     = 32;
    localparam int LEV_W    = 7;

    // MSR bit positions, counted from the least significant bit
    localparam int MSR_RI_B = 1;
    localparam int MSR_DR_B = 4;
    localparam int MSR_IR_B = 5;
    localparam int MSR_PR_B = 14;
    localparam int MSR_EE_B = 15;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_ENTER,
        EV_LEAVE,
        EV_TRAP
    } svc_ev_e;

    typedef struct packed {
        logic               is_call;
        logic               is_ret;
        logic               rsvd_bad;
        logic [LEV_W-1:0]   lev;
    } svc_dec_t;

endpackage

// File: rtl/svc_decode.sv
module svc_decode
    import svc_pkg::*;
#(
    parameter int CALL_OPC = 17,
    parameter int RET_OPC  = 19,
    parameter int RET_XO   = 82,
    parameter int LEV_LO   = 5
) (
    input  logic [ILEN-1:0] instr,
    output svc_dec_t        dec
);
    localparam int OPC_W  = 6;
    localparam int OPC_LO = ILEN - OPC_W;
    localparam int XO_W   = 10;
    localparam int LEV_HI = LEV_LO + LEV_W - 1;

    logic [OPC_W-1:0] opc;
    logic             call_hit;
    logic             ret_hit;
    logic             call_rsvd;
    logic             ret_rsvd;

    always_comb begin
        opc       = instr[ILEN-1:OPC_LO];
        call_hit  = (opc == OPC_W'(CALL_OPC)) && (instr[1:0] == 2'b01);
        ret_hit   = (opc == OPC_W'(RET_OPC)) && (instr[XO_W:1] == XO_W'(RET_XO));
        call_rsvd = (|instr[25:12]) || (|instr[4:2]);
        ret_rsvd  = (|instr[25:15]) || instr[0];

        dec.is_call  = call_hit;
        dec.is_ret   = ret_hit;
        dec.rsvd_bad = (call_hit && call_rsvd) || (ret_hit && ret_rsvd);
        dec.lev      = instr[LEV_HI:LEV_LO];
    end

endmodule

// File: rtl/svc_target.sv
module svc_target
    import svc_pkg::*;
#(
    parameter logic [XLEN-1:0] HI_BASE   = 64'hC000_0000_0000_3000,
    parameter logic [XLEN-1:0] LO_BASE   = 64'h0000_0000_0001_7000,
    parameter int              HI_MODE   = 3,
    parameter int              STRIDE_SH = 5
) (
    input  logic [1:0]       ail_mode,
    input  logic             to_hyp,
    input  logic [XLEN-1:0]  msr,
    input  logic [LEV_W-1:0] lev,
    output logic [XLEN-1:0]  target,
    output logic             ail_on
);
    logic [1:0]      ail_eff;
    logic            xlate_on;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    always_comb begin
        xlate_on = msr[MSR_IR_B] && msr[MSR_DR_B];
        ail_eff  = (to_hyp || !xlate_on) ? 2'd0 : ail_mode;
        ail_on   = (ail_eff != 2'd0);
        base     = (ail_eff == 2'(HI_MODE)) ? HI_BASE : LO_BASE;
        offs     = XLEN'(lev) << STRIDE_SH;
        target   = base + offs;
    end

endmodule

// File: rtl/svc_vector_unit.sv
module svc_vector_unit
    import svc_pkg::*;
#(
    parameter int FAC_BIT   = 12,
    parameter int FU_CAUSE  = 12,
    parameter int CAUSE_W   = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_valid,
    input  logic [ILEN-1:0]  instr,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  msr,
    input  logic [XLEN-1:0]  fscr,
    input  logic [1:0]       ail_mode,
    input  logic             to_hyp,
    input  logic             feat_present,
    output logic [XLEN-1:0]  lr,
    output logic [XLEN-1:0]  ctr,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             msr_wr,
    output logic [XLEN-1:0]  msr_new,
    output logic             fu_exc,
    output logic [XLEN-1:0]  fscr_new,
    output logic             priv_exc,
    output logic             ill_exc
);
    localparam int CAUSE_LO = XLEN - CAUSE_W;
    localparam logic [XLEN-1:0] KEEP_MASK =
        (XLEN'(1) << MSR_EE_B) | (XLEN'(1) << MSR_RI_B);
    localparam logic [XLEN-1:0] RELOC_MASK =
        (XLEN'(1) << MSR_IR_B) | (XLEN'(1) << MSR_DR_B);

    typedef struct packed {
        logic [XLEN-1:0] lr;
        logic [XLEN-1:0] ctr;
        logic            redir;
        logic [XLEN-1:0] redir_pc;
        logic            msr_wr;
        logic [XLEN-1:0] msr_val;
        logic            fu;
        logic [XLEN-1:0] fscr_val;
        logic            priv;
        logic            ill;
        svc_ev_e         ev;
    } unit_st_t;

    svc_dec_t        dec;
    logic [XLEN-1:0] tgt;
    logic            ail_on;
    logic            fac_ok;
    unit_st_t        st_d, st_q;

    svc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    svc_target u_tgt (
        .ail_mode (ail_mode),
        .to_hyp   (to_hyp),
        .msr      (msr),
        .lev      (dec.lev),
        .target   (tgt),
        .ail_on   (ail_on)
    );

    always_comb begin
        fac_ok = feat_present && fscr[FAC_BIT];

        st_d          = st_q;
        st_d.redir    = 1'b0;
        st_d.msr_wr   = 1'b0;
        st_d.fu       = 1'b0;
        st_d.priv     = 1'b0;
        st_d.ill      = 1'b0;
        st_d.ev       = EV_IDLE;

        if (exec_valid && (dec.is_call || dec.is_ret)) begin
            if (dec.rsvd_bad) begin
                st_d.ill = 1'b1;
                st_d.ev  = EV_TRAP;
            end else if (dec.is_call) begin
                if (!fac_ok) begin
                    st_d.fu       = 1'b1;
                    st_d.fscr_val = {CAUSE_W'(FU_CAUSE), fscr[CAUSE_LO-1:0]};
                    st_d.ev       = EV_TRAP;
                end else begin
                    st_d.lr       = pc + XLEN'(INSN_BYTES);
                    st_d.ctr      = msr;
                    st_d.redir    = 1'b1;
                    st_d.redir_pc = tgt;
                    st_d.msr_wr   = 1'b1;
                    st_d.msr_val  = (msr & KEEP_MASK) |
                                    (ail_on ? RELOC_MASK : '0);
                    st_d.ev       = EV_ENTER;
                end
            end else begin
                if (msr[MSR_PR_B]) begin
                    st_d.priv = 1'b1;
                    st_d.ev   = EV_TRAP;
                end else begin
                    st_d.redir    = 1'b1;
                    st_d.redir_pc = st_q.lr;
                    st_d.msr_wr   = 1'b1;
                    st_d.msr_val  = st_q.ctr;
                    st_d.ev       = EV_LEAVE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lr: '0, ctr: '0, redir: 1'b0, redir_pc: '0,
                      msr_wr: 1'b0, msr_val: '0, fu: 1'b0, fscr_val: '0,
                      priv: 1'b0, ill: 1'b0, ev: EV_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign lr             = st_q.lr;
    assign ctr            = st_q.ctr;
    assign redirect_valid = st_q.redir;
    assign redirect_pc    = st_q.redir_pc;
    assign msr_wr         = st_q.msr_wr;
    assign msr_new        = st_q.msr_val;
    assign fu_exc         = st_q.fu;
    assign fscr_new       = st_q.fscr_val;
    assign priv_exc       = st_q.priv;
    assign ill_exc        = st_q.ill;

    // R11: results are mutually exclusive
    p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect_valid, fu_exc, priv_exc, ill_exc}));

    // R5: enabled call saves return address and old state
    p_entry_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && dec.is_call && !dec.rsvd_bad && fac_ok)
        |=> (lr == $past(pc) + XLEN'(INSN_BYTES)) && (ctr == $past(msr))
            && redirect_valid);

    // R7: a facility fault leaves the link register alone
    p_fu_keeps_lr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fu_exc) |-> $stable(lr) && !redirect_valid);

    // R6: entry MSR carries only the permitted bits
    p_entry_msr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ev == EV_ENTER) |-> msr_wr &&
        ((msr_new & ~(KEEP_MASK | RELOC_MASK)) == '0));

    // R8: return restores from the link and count registers
    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && dec.is_ret && !dec.rsvd_bad && !msr[MSR_PR_B])
        |=> redirect_valid && (redirect_pc == $past(lr))
            && (msr_new == $past(ctr)));

    // R9: privileged fault performs no write
    p_priv_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        priv_exc |-> !msr_wr && !redirect_valid);

endmodule

// File: tb/svc_vector_unit_test.sv
module svc_vector_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_valid;
    logic [31:0] instr;
    logic [63:0] pc, msr, fscr;
    logic [1:0]  ail_mode;
    logic        to_hyp, feat_present;
    logic [63:0] lr, ctr, redirect_pc, msr_new, fscr_new;
    logic        redirect_valid, msr_wr, fu_exc, priv_exc, ill_exc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    svc_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(instr),
        .pc(pc), .msr(msr), .fscr(fscr), .ail_mode(ail_mode),
        .to_hyp(to_hyp), .feat_present(feat_present),
        .lr(lr), .ctr(ctr), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .msr_wr(msr_wr), .msr_new(msr_new),
        .fu_exc(fu_exc), .fscr_new(fscr_new), .priv_exc(priv_exc),
        .ill_exc(ill_exc)
    );

    localparam logic [63:0] FAC_ON = 64'h1000;

    function automatic logic [31:0] call_word(input int lev);
        return (32'd17 << 26) | (32'(lev) << 5) | 32'd1;
    endfunction

    localparam logic [31:0] RET_WORD = (32'd19 << 26) | (32'd82 << 1);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fire(input logic [31:0] w);
        @(negedge clk);
        instr      = w;
        exec_valid = 1'b1;
        @(negedge clk);
        exec_valid = 1'b0;
    endtask

    task automatic flags(input string req, input logic r, input logic f,
                         input logic p, input logic i);
        chk(req, "redirect_valid", 64'(redirect_valid), 64'(r));
        chk(req, "fu_exc",         64'(fu_exc),         64'(f));
        chk(req, "priv_exc",       64'(priv_exc),       64'(p));
        chk(req, "ill_exc",        64'(ill_exc),        64'(i));
    endtask

    task automatic t_reset;
        chk("R11", "lr after reset",  lr,  64'h0);
        chk("R11", "ctr after reset", ctr, 64'h0);
        flags("R11", 0, 0, 0, 0);
        chk("R11", "msr_wr after reset", 64'(msr_wr), 64'h0);
    endtask

    task automatic t_call_low;
        pc = 64'h0000_0000_0040_0100; msr = 64'h4000_0000_0000_8000;
        ail_mode = 2'd0; to_hyp = 0; feat_present = 1; fscr = FAC_ON;
        fire(call_word(5));
        flags("R5", 1, 0, 0, 0);
        chk("R5", "lr", lr, 64'h0000_0000_0040_0104);
        chk("R5", "ctr", ctr, 64'h4000_0000_0000_8000);
        chk("R2", "target lev5", redirect_pc, 64'h0000_0000_0001_70A0);
        chk("R6", "msr_new", msr_new, 64'h8000);
        chk("R6", "msr_wr", 64'(msr_wr), 64'h1);
        @(negedge clk);
        chk("R11", "redirect pulse width", 64'(redirect_valid), 64'h0);
        chk("R11", "msr_wr pulse width", 64'(msr_wr), 64'h0);
    endtask

    task automatic t_call_high;
        pc = 64'h0000_7000_0000_0000; msr = 64'h1000_0000_0000_8032;
        ail_mode = 2'd3; to_hyp = 0;
        fire(call_word(127));
        chk("R3", "high base lev127", redirect_pc, 64'hC000_0000_0000_3FE0);
        chk("R6", "msr_new reloc", msr_new, 64'h8032);
        chk("R5", "ctr", ctr, 64'h1000_0000_0000_8032);
    endtask

    task automatic t_ail_hyp;
        msr = 64'h30; ail_mode = 2'd3; to_hyp = 1;
        fire(call_word(1));
        chk("R4", "hyp forces low base", redirect_pc, 64'h0000_0000_0001_7020);
        chk("R4", "hyp clears reloc", msr_new, 64'h0);
        to_hyp = 0;
    endtask

    task automatic t_ail_xoff;
        msr = 64'h20; ail_mode = 2'd3;
        fire(call_word(0));
        chk("R4", "xlate off low base", redirect_pc, 64'h0000_0000_0001_7000);
        chk("R4", "xlate off no reloc", msr_new, 64'h0);
    endtask

    task automatic t_ail_mode2;
        msr = 64'h32; ail_mode = 2'd2;
        fire(call_word(2));
        chk("R3", "mode2 low base", redirect_pc, 64'h0000_0000_0001_7040);
        chk("R6", "mode2 reloc set", msr_new, 64'h32);
    endtask

    task automatic t_fac_off;
        logic [63:0] lr0;
        lr0 = lr;
        fscr = 64'h0000_0000_0000_0ABC; feat_present = 1;
        fire(call_word(3));
        flags("R7", 0, 1, 0, 0);
        chk("R7", "fscr cause", fscr_new, 64'h0C00_0000_0000_0ABC);
        chk("R7", "lr unchanged", lr, lr0);
        fscr = FAC_ON; feat_present = 0;
        fire(call_word(3));
        flags("R7", 0, 1, 0, 0);
        chk("R7", "lr unchanged feat absent", lr, lr0);
        feat_present = 1;
    endtask

    task automatic t_return;
        logic [63:0] lr0, ctr0;
        msr = 64'h8000; ail_mode = 2'd0; pc = 64'h0000_0000_1234_5670;
        fire(call_word(9));
        lr0 = lr; ctr0 = ctr;
        chk("R5", "lr before return", lr0, 64'h0000_0000_1234_5674);
        msr = 64'h0;
        fire(RET_WORD);
        flags("R8", 1, 0, 0, 0);
        chk("R8", "return pc", redirect_pc, lr0);
        chk("R8", "return msr", msr_new, ctr0);
        chk("R8", "return msr_wr", 64'(msr_wr), 64'h1);
    endtask

    task automatic t_return_priv;
        msr = 64'h4000;
        fire(RET_WORD);
        flags("R9", 0, 0, 1, 0);
        chk("R9", "no msr write", 64'(msr_wr), 64'h0);
    endtask

    task automatic t_illegal;
        logic [63:0] lr0;
        lr0 = lr;
        fscr = 64'h0; msr = 64'h8000;
        fire(call_word(4) | (32'd1 << 20));
        flags("R10", 0, 0, 0, 1);
        chk("R10", "lr unchanged", lr, lr0);
        fire(call_word(4) | (32'd1 << 3));
        flags("R10", 0, 0, 0, 1);
        msr = 64'h4000;
        fire(RET_WORD | 32'd1);
        flags("R10", 0, 0, 0, 1);
        fscr = FAC_ON; msr = 64'h0;
        fire(RET_WORD | (32'd1 << 12));
        flags("R10", 1, 0, 0, 0);
    endtask

    task automatic t_plain_sc;
        logic [63:0] lr0, ctr0;
        lr0 = lr; ctr0 = ctr;
        fire((32'd17 << 26) | (32'd6 << 5) | 32'd2);
        flags("R1", 0, 0, 0, 0);
        chk("R1", "lr unchanged", lr, lr0);
        chk("R1", "ctr unchanged", ctr, ctr0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; exec_valid = 0; instr = '0; pc = '0; msr = '0;
        fscr = FAC_ON; ail_mode = 2'd0; to_hyp = 0; feat_present = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_call_low();
        t_call_high();
        t_ail_hyp();
        t_ail_xoff();
        t_ail_mode2();
        t_fac_off();
        t_return();
        t_return_priv();
        t_illegal();
        t_plain_sc();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

endmodule